// File: doc/BRIEF.md
# Address-masked GPIO port

An eight-pin general-purpose I/O port on a simple APB-style bus. Each pin has a direction bit and a data bit. A pin whose direction bit is set drives its data bit onto the pad with its output enable raised. A pin whose direction bit is clear is an input. Its pad level passes through a two-flop synchronizer before software can read it.

The data register is not at a single address. It is mirrored across the whole lowest 1 KB of the address space. The word-address bits of a data access act as a per-pin mask. A write therefore changes only the selected pins, so software never needs a read-modify-write to toggle one pin. A read returns zeros in every unselected bit position. Eight read-only identification bytes sit at the top of the 4 KB space. Every bus transfer completes in its access cycle with no wait states.

Top module: `gpio_mask_port`

## Requirements
- R1: After reset the data and direction registers are zero, so `pin_out` and `pin_oe` are all zero and every pin is an input.
- R2: A write to any address below 0x400 updates data bit i with `pwdata[i]` only where address bit i+2 is 1. Data bits whose address bit is 0 keep their value.
- R3: A read of any address below 0x400 returns the pin value in bit i where address bit i+2 is 1, and 0 where it is 0. `prdata` bits 31..8 read 0.
- R4: The direction register is at byte offset 0x400 and reads back as written. A 1 in bit i makes pin i an output, and `pin_oe[i]` equals that bit.
- R5: `pin_out[i]` always equals data register bit i, whatever the pin's direction.
- R6: In a data read, an output pin returns its data register bit. An input pin returns `pin_in` as it stood two rising edges earlier, through a two-flop synchronizer.
- R7: Offsets 0xFE0, 0xFE4, 0xFE8 and 0xFEC read 0x61, 0x10, 0x04 and 0x00.
- R8: Offsets 0xFF0, 0xFF4, 0xFF8 and 0xFFC read 0x0D, 0xF0, 0x05 and 0xB1.
- R9: Writes to the identification offsets or to unmapped offsets change no register. Reads of unmapped offsets return 0.
- R10: `pready` is always 1. A write takes effect at the rising edge that ends its access cycle (`psel` and `penable` high), and no register changes in any other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address |
| pwdata | input | 32 | Write data (bits 7..0 used) |
| prdata | output | 32 | Read data, valid combinationally in the access cycle |
| pready | output | 1 | Transfer complete, tied high |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |

## Verification
Read data is combinational in the access cycle, so the bench samples `prdata` a quarter period after the falling edge that raises `penable`. Register writes appear on `pin_out` and `pin_oe` one edge after the access cycle, and the reference model applies each write at that same edge. An input change reaches read data only after the second rising edge. A dedicated sequence holds a read open while `pin_in` changes and expects the old value for two samples and the new value on the third. The behavioural model tracks this with a two-entry history queue. Outputs, `pready` and any open read are compared against the model one time unit after every rising edge.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;

    localparam int GPIO_PINS  = 8;
    localparam int GPIO_ADDR  = 12;
    localparam int GPIO_BUS_W = 32;
    localparam int SYNC_DEPTH = 2;

    typedef enum logic [1:0] {
        RG_NONE = 2'd0,
        RG_DATA = 2'd1,
        RG_DIR  = 2'd2,
        RG_ID   = 2'd3
    } region_e;

    typedef struct packed {
        logic    rd;
        logic    wr;
        region_e region;
        logic [2:0] id_idx;
    } bus_op_t;

    function automatic logic [7:0] id_byte(input logic [2:0] idx);
        logic [7:0] b;
        case (idx)
            3'd0:    b = 8'h61;
            3'd1:    b = 8'h10;
            3'd2:    b = 8'h04;
            3'd3:    b = 8'h00;
            3'd4:    b = 8'h0D;
            3'd5:    b = 8'hF0;
            3'd6:    b = 8'h05;
            default: b = 8'hB1;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
    import gpio_mask_pkg::*;
#(
    parameter int N_PINS = GPIO_PINS,
    parameter int ADDR_W = GPIO_ADDR
) (
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    output bus_op_t           op,
    output logic [N_PINS-1:0] mask
);
    localparam int WORD_W = ADDR_W - 2;
    localparam logic [WORD_W-1:0] DIR_WORD = WORD_W'(1) << N_PINS;

    logic [WORD_W-1:0] word;
    logic              access;
    logic              unused_lsb;

    assign word       = paddr[ADDR_W-1:2];
    assign unused_lsb = ^paddr[1:0];
    assign access     = psel & penable;
    assign mask       = word[N_PINS-1:0];

    always_comb begin
        op        = '0;
        op.rd     = access & ~pwrite;
        op.wr     = access & pwrite;
        op.id_idx = word[2:0];
        if (word[WORD_W-1:N_PINS] == '0)
            op.region = RG_DATA;
        else if (word == DIR_WORD)
            op.region = RG_DIR;
        else if (&word[WORD_W-1:3])
            op.region = RG_ID;
        else
            op.region = RG_NONE;
    end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int N_PINS = 8,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_PINS-1:0] d,
    output logic [N_PINS-1:0] q
);
    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
        logic [STAGES-1:0] sh;
        always_ff @(posedge clk) begin
            if (rst)
                sh <= '0;
            else
                sh <= {sh[STAGES-2:0], d[i]};
        end
        assign q[i] = sh[STAGES-1];
    end

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_mask_pkg::*;
#(
    parameter int N_PINS = GPIO_PINS
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_op_t           op,
    input  logic [N_PINS-1:0] mask,
    input  logic [N_PINS-1:0] wdata,
    output logic [N_PINS-1:0] data_q,
    output logic [N_PINS-1:0] dir_q
);
    logic unused_op;
    assign unused_op = op.rd ^ (^op.id_idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            dir_q  <= '0;
        end else if (op.wr) begin
            case (op.region)
                RG_DATA: data_q <= (data_q & ~mask) | (wdata & mask);
                RG_DIR:  dir_q  <= wdata;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
    import gpio_mask_pkg::*;
#(
    parameter int N_PINS = GPIO_PINS,
    parameter int BUS_W  = GPIO_BUS_W
) (
    input  bus_op_t           op,
    input  logic [N_PINS-1:0] mask,
    input  logic [N_PINS-1:0] data_q,
    input  logic [N_PINS-1:0] dir_q,
    input  logic [N_PINS-1:0] pin_sync,
    output logic [BUS_W-1:0]  prdata
);
    logic [N_PINS-1:0] pin_view;
    logic              unused_wr;
    assign unused_wr = op.wr;

    for (genvar i = 0; i < N_PINS; i++) begin : g_view
        assign pin_view[i] = dir_q[i] ? data_q[i] : pin_sync[i];
    end

    always_comb begin
        prdata = '0;
        if (op.rd) begin
            case (op.region)
                RG_DATA: prdata[N_PINS-1:0] = pin_view & mask;
                RG_DIR:  prdata[N_PINS-1:0] = dir_q;
                RG_ID:   prdata[7:0]        = id_byte(op.id_idx);
                default: prdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
    import gpio_mask_pkg::*;
#(
    parameter int N_PINS = GPIO_PINS,
    parameter int ADDR_W = GPIO_ADDR,
    parameter int BUS_W  = GPIO_BUS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [BUS_W-1:0]  pwdata,
    output logic [BUS_W-1:0]  prdata,
    output logic              pready,
    input  logic [N_PINS-1:0] pin_in,
    output logic [N_PINS-1:0] pin_out,
    output logic [N_PINS-1:0] pin_oe
);
    bus_op_t           op;
    logic [N_PINS-1:0] mask;
    logic [N_PINS-1:0] data_q;
    logic [N_PINS-1:0] dir_q;
    logic [N_PINS-1:0] pin_sync;
    logic              unused_wdata;

    assign unused_wdata = ^pwdata[BUS_W-1:N_PINS];

    gpio_addr_dec #(.N_PINS(N_PINS), .ADDR_W(ADDR_W)) u_dec (
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .op      (op),
        .mask    (mask)
    );

    gpio_in_sync #(.N_PINS(N_PINS), .STAGES(SYNC_DEPTH)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (pin_sync)
    );

    gpio_port_regs #(.N_PINS(N_PINS)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .op     (op),
        .mask   (mask),
        .wdata  (pwdata[N_PINS-1:0]),
        .data_q (data_q),
        .dir_q  (dir_q)
    );

    gpio_read_mux #(.N_PINS(N_PINS), .BUS_W(BUS_W)) u_rmux (
        .op       (op),
        .mask     (mask),
        .data_q   (data_q),
        .dir_q    (dir_q),
        .pin_sync (pin_sync),
        .prdata   (prdata)
    );

    assign pready  = 1'b1;
    assign pin_out = data_q;
    assign pin_oe  = dir_q;

endmodule

// File: rtl/gpio_mask_port_chk.sv
module gpio_mask_port_chk #(
    parameter int N_PINS = 8,
    parameter int ADDR_W = 12,
    parameter int BUS_W  = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-3:0] waddr,
    input logic [N_PINS-1:0] wdata,
    input logic [BUS_W-1:0]  prdata,
    input logic              pready,
    input logic [N_PINS-1:0] pin_out,
    input logic [N_PINS-1:0] pin_oe
);
    localparam int WORD_W = ADDR_W - 2;
    localparam logic [WORD_W-1:0] DIR_WORD = WORD_W'(1) << N_PINS;

    logic              acc_wr, acc_rd, in_data, in_dir, in_id;
    logic [N_PINS-1:0] sel;

    assign acc_wr  = psel && penable && pwrite;
    assign acc_rd  = psel && penable && !pwrite;
    assign in_data = (waddr[WORD_W-1:N_PINS] == '0);
    assign in_dir  = (waddr == DIR_WORD);
    assign in_id   = &waddr[WORD_W-1:3];
    assign sel     = waddr[N_PINS-1:0];

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (pin_out == '0 && pin_oe == '0));

    p_mask_set_r2: assert property (@(posedge clk) disable iff (rst)
        (acc_wr && in_data) |=> (((pin_out ^ $past(wdata)) & $past(sel)) == '0));

    p_mask_keep_r2: assert property (@(posedge clk) disable iff (rst)
        (acc_wr && in_data) |=> (((pin_out ^ $past(pin_out)) & ~$past(sel)) == '0));

    p_dir_write_r4: assert property (@(posedge clk) disable iff (rst)
        (acc_wr && in_dir) |=> (pin_oe == $past(wdata)));

    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (acc_rd && !in_data && !in_dir && !in_id) |-> (prdata == '0));

    p_no_wait_r10: assert property (@(posedge clk) disable iff (rst)
        psel |-> pready);

    p_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !acc_wr |=> ($stable(pin_out) && $stable(pin_oe)));

endmodule

bind gpio_mask_port gpio_mask_port_chk #(
    .N_PINS (N_PINS),
    .ADDR_W (ADDR_W),
    .BUS_W  (BUS_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .waddr   (paddr[ADDR_W-1:2]),
    .wdata   (pwdata[N_PINS-1:0]),
    .prdata  (prdata),
    .pready  (pready),
    .pin_out (pin_out),
    .pin_oe  (pin_oe)
);

// File: tb/gpio_mask_port_tb.sv
module gpio_mask_port_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready;
    logic [7:0]  pin_in = '0;
    logic [7:0]  pin_out, pin_oe;

    int n_checks = 0;
    int n_fail   = 0;
    bit started  = 1'b0;

    logic [7:0] m_data = '0;
    logic [7:0] m_dir  = '0;
    logic [7:0] inq[$] = '{8'h00, 8'h00};

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_mask_port u_dut (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, got, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_rd(input logic [11:0] a);
        logic [7:0] v;
        logic [7:0] ids [8] = '{8'h61, 8'h10, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        if (a < 12'h400) begin
            v = (m_dir & m_data) | (~m_dir & inq[1]);
            return {24'h0, v & a[9:2]};
        end
        if (a[11:2] == 10'h100) return {24'h0, m_dir};
        if (a >= 12'hFE0) return {24'h0, ids[a[4:2]]};
        return 32'h0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_data = '0;
            m_dir  = '0;
            inq    = '{8'h00, 8'h00};
        end else begin
            if (psel && penable && pwrite) begin
                if (paddr < 12'h400)
                    m_data = (m_data & ~paddr[9:2]) | (pwdata[7:0] & paddr[9:2]);
                else if (paddr[11:2] == 10'h100)
                    m_dir = pwdata[7:0];
            end
            inq.push_front(pin_in);
            void'(inq.pop_back());
        end
    end

    always @(posedge clk) begin
        #1;
        if (started) begin
            chk("R5 pin_out", {24'h0, pin_out}, {24'h0, m_data});
            chk("R4 pin_oe", {24'h0, pin_oe}, {24'h0, m_dir});
            chk("R10 pready", {31'h0, pready}, 32'h1);
            if (psel && penable && !pwrite)
                chk("R3 prdata", prdata, exp_rd(paddr));
        end
    end

    task automatic xfer(input logic wr, input logic [11:0] a, input logic [31:0] wd,
                        output logic [31:0] rd);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = wd;
        @(negedge clk);
        penable = 1'b1;
        #(CLK_PERIOD/4);
        rd = prdata;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R10 watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic [7:0]  ids [8] = '{8'h61, 8'h10, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        started = 1'b1;

        // R1: reset state
        chk("R1 pin_out", {24'h0, pin_out}, 32'h0);
        chk("R1 pin_oe", {24'h0, pin_oe}, 32'h0);
        xfer(1'b0, 12'h400, 32'h0, rd);
        chk("R1 dir read", rd, 32'h0);

        // R4: direction write and readback
        xfer(1'b1, 12'h400, 32'hFFFF_FFF0, rd);
        chk("R4 pin_oe", {24'h0, pin_oe}, 32'hF0);
        xfer(1'b0, 12'h400, 32'h0, rd);
        chk("R4 dir read", rd, 32'hF0);

        // R2 / R5: masked writes
        xfer(1'b1, 12'h0C0, 32'h0000_00FF, rd);      // mask 0x30
        chk("R2 mask 0x30", {24'h0, pin_out}, 32'h30);
        xfer(1'b1, 12'h204, 32'h0000_0001, rd);      // mask 0x81, sets bit0, clears bit7
        chk("R2 mask 0x81", {24'h0, pin_out}, 32'h31);
        xfer(1'b1, 12'h000, 32'h0000_00FF, rd);      // mask 0: no change
        chk("R2 empty mask", {24'h0, pin_out}, 32'h31);

        // R6 / R3: mixed directions
        @(negedge clk); pin_in = 8'h0A;
        repeat (3) @(negedge clk);
        xfer(1'b0, 12'h3FC, 32'h0, rd);
        chk("R6 mixed read", rd, 32'h3A);
        xfer(1'b0, 12'h03C, 32'h0, rd);
        chk("R3 low nibble mask", rd, 32'h0A);
        xfer(1'b0, 12'h000, 32'h0, rd);
        chk("R3 zero mask", rd, 32'h0);
        xfer(1'b0, 12'h100, 32'h0, rd);
        chk("R3 single bit6 mask", rd, 32'h0);

        // R6: synchronizer latency with a held read
        @(negedge clk);
        psel = 1'b1; penable = 1'b1; pwrite = 1'b0; paddr = 12'h03C; pin_in = 8'h05;
        #(CLK_PERIOD/4);
        chk("R6 latency 0", prdata, 32'h0A);
        @(negedge clk); #(CLK_PERIOD/4);
        chk("R6 latency 1", prdata, 32'h0A);
        @(negedge clk); #(CLK_PERIOD/4);
        chk("R6 latency 2", prdata, 32'h05);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;

        // R7 / R8: identification bytes
        for (int i = 0; i < 8; i++) begin
            xfer(1'b0, 12'hFE0 + 12'(4*i), 32'h0, rd);
            chk(i < 4 ? "R7 periph id" : "R8 cell id", rd, {24'h0, ids[i]});
        end

        // R9: ignored writes and unmapped reads
        xfer(1'b1, 12'hFE0, 32'h0000_00FF, rd);
        xfer(1'b0, 12'hFE0, 32'h0, rd);
        chk("R9 id write ignored", rd, 32'h61);
        xfer(1'b1, 12'h800, 32'h0000_00FF, rd);
        chk("R9 unmapped write out", {24'h0, pin_out}, 32'h31);
        chk("R9 unmapped write oe", {24'h0, pin_oe}, 32'hF0);
        xfer(1'b0, 12'h800, 32'h0, rd);
        chk("R9 unmapped read", rd, 32'h0);
        xfer(1'b0, 12'h404, 32'h0, rd);
        chk("R9 unmapped 0x404", rd, 32'h0);

        // R5: output value kept on a pin switched to input
        xfer(1'b1, 12'h400, 32'h0000_0000, rd);
        chk("R5 out after dir clear", {24'h0, pin_out}, 32'h31);
        xfer(1'b0, 12'h3FC, 32'h0, rd);
        chk("R6 all inputs", rd, 32'h05);

        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule